// File: doc/BRIEF.md
# Effective Address Generation Unit

This block computes the address of a memory operand for a load or a store. It adds three terms: an optional base register, an optional index register shifted left by a 2-bit scale code, and a signed displacement that is sign-extended from 8 or 32 bits. The sum is the offset. The block then adds a segment base to the offset to give the linear address. When the segment base is zero, the linear address equals the offset. A mode input selects 32-bit or 64-bit address arithmetic. In 32-bit mode every operand is cut to its low 32 bits, every sum wraps modulo 2^32, and the upper output bits are zero.

Requests arrive on a valid/ready input and results leave on a valid/ready output. There is one register stage between them. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high, and its result is shown on the next cycle. A result stays on the outputs, unchanged, until a cycle with `out_ready` high. While a result is held without `out_ready`, `in_ready` stays low and no new request is taken. When the held result is taken, a new request can be accepted on the same edge.

Top module: `eff_addr_gen`

## Requirements
- R1: `out_offset` equals base + (index << `scale_sel`) + sign-extended displacement, where scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R2: With `disp_sz` = 2'b01, only `disp_raw[7:0]` is used. It is read as two's complement and sign-extended, so the upper bits of `disp_raw` have no effect.
- R3: With `disp_sz` = 2'b10, `disp_raw` is a 32-bit two's-complement value. In 64-bit mode it is sign-extended to 64 bits.
- R4: With `disp_sz` = 2'b00 (none) or 2'b11 (reserved), the displacement adds zero.
- R5: When `base_en` is low, the base adds zero, whatever `base_val` holds. A 32-bit displacement then acts as the absolute base, and an index with no base and no displacement gives the scaled index alone.
- R6: When `idx_en` is low, the index adds zero, whatever `idx_val` and `scale_sel` hold.
- R7: `out_linear` equals `seg_base` + `out_offset`. With a zero segment base, `out_linear` equals `out_offset`.
- R8: With `wide_mode` = 0, only the low 32 bits of every operand are used. All sums wrap modulo 2^32, and bits 63:32 of both outputs are zero.
- R9: With `wide_mode` = 1, all sums wrap modulo 2^64.
- R10: A request accepted on one rising edge makes `out_valid` high, with its result on the outputs, in the next cycle.
- R11: While `out_valid` is high and `out_ready` is low, the outputs stay stable and `in_ready` is low.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | The block can accept a request |
| base_val | input | 64 | Base register value |
| base_en | input | 1 | A base register is present |
| idx_val | input | 64 | Index register value |
| idx_en | input | 1 | An index register is present |
| scale_sel | input | 2 | Index shift amount (0 to 3) |
| disp_raw | input | 32 | Raw displacement bits |
| disp_sz | input | 2 | Displacement size: 00 none, 01 8-bit, 10 32-bit, 11 none |
| wide_mode | input | 1 | 1 selects 64-bit addressing, 0 selects 32-bit |
| seg_base | input | 64 | Segment base |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_offset | output | 64 | Computed offset |
| out_linear | output | 64 | Segment base plus offset |

## Verification
The assertions check on every cycle the handshake rules:
- a held result stays stable and blocks the input;
- an accepted request shows up one cycle later;
- in 32-bit mode the upper output bits are zero.

Inside the logic, they also check that an 8-bit displacement extends its sign bit and that a zero segment base passes the offset through. Only the bench scenarios can show the arithmetic itself. These cover:
- the negative displacements;
- the absent base and absent index forms;
- the reserved size code;
- wraparound at 2^32 and at 2^64.

In each of these the computed value is compared with a value worked out by hand.

// File: rtl/eagu_pkg.sv
package eagu_pkg;
  localparam int ADDR_W  = 64;
  localparam int NARROW_W = 32;
  localparam int DISP_W  = 32;
  localparam int SHORT_W = 8;

  typedef enum logic [1:0] {
    DSZ_NONE  = 2'b00,
    DSZ_SHORT = 2'b01,
    DSZ_LONG  = 2'b10,
    DSZ_RSVD  = 2'b11
  } disp_size_e;
endpackage

// File: rtl/eagu_disp_ext.sv
module eagu_disp_ext
  import eagu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DISP_W,
  parameter int SW = SHORT_W
) (
  input  logic [DW-1:0] disp_raw,
  input  logic [1:0]    disp_sz,
  output logic [AW-1:0] disp_ext
);
  localparam int SHORT_PAD = AW - SW;
  localparam int LONG_PAD  = AW - DW;

  always_comb begin
    unique case (disp_size_e'(disp_sz))
      DSZ_SHORT: disp_ext = {{SHORT_PAD{disp_raw[SW-1]}}, disp_raw[SW-1:0]};
      DSZ_LONG:  disp_ext = {{LONG_PAD{disp_raw[DW-1]}}, disp_raw};
      default:   disp_ext = '0;  // none and reserved codes add zero
    endcase
  end

  // R2: a short displacement fills every upper bit with its sign
  always_comb begin
    if (disp_sz == DSZ_SHORT)
      p_short_sign_r2: assert (disp_ext[AW-1:SW] == {SHORT_PAD{disp_ext[SW-1]}});
  end
endmodule

// File: rtl/eagu_sum.sv
module eagu_sum
  import eagu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NARROW_W
) (
  input  logic [AW-1:0] base_val,
  input  logic          base_en,
  input  logic [AW-1:0] idx_val,
  input  logic          idx_en,
  input  logic [1:0]    scale_sel,
  input  logic [AW-1:0] disp_ext,
  input  logic [AW-1:0] seg_base,
  input  logic          wide_mode,
  output logic [AW-1:0] offset,
  output logic [AW-1:0] linear
);
  localparam logic [AW-1:0] NARROW_MASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  logic [AW-1:0] mask, base_term, idx_term, disp_term, seg_term, off_raw, lin_raw;

  always_comb begin
    mask      = wide_mode ? '1 : NARROW_MASK;
    base_term = base_en ? (base_val & mask) : '0;
    idx_term  = idx_en ? ((idx_val & mask) << scale_sel) : '0;
    disp_term = disp_ext & mask;
    seg_term  = seg_base & mask;
    off_raw   = base_term + idx_term + disp_term;
    offset    = off_raw & mask;
    lin_raw   = seg_term + offset;
    linear    = lin_raw & mask;
  end

  // R7: a zero segment base passes the offset through unchanged
  always_comb begin
    if (seg_base == '0)
      p_flat_seg_r7: assert (linear == offset);
  end
endmodule

// File: rtl/eagu_out_stage.sv
module eagu_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  always_comb in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eagu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NW = NARROW_W,
  parameter int DW = DISP_W,
  parameter int SW = SHORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] base_val,
  input  logic          base_en,
  input  logic [AW-1:0] idx_val,
  input  logic          idx_en,
  input  logic [1:0]    scale_sel,
  input  logic [DW-1:0] disp_raw,
  input  logic [1:0]    disp_sz,
  input  logic          wide_mode,
  input  logic [AW-1:0] seg_base,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_offset,
  output logic [AW-1:0] out_linear
);
  localparam int PW = 2 * AW + 1;

  logic [AW-1:0] disp_ext, offset_c, linear_c;
  logic [PW-1:0] pay_in, pay_out;
  logic          held_wide;

  eagu_disp_ext #(.AW(AW), .DW(DW), .SW(SW)) u_disp (
    .disp_raw(disp_raw), .disp_sz(disp_sz), .disp_ext(disp_ext)
  );

  eagu_sum #(.AW(AW), .NW(NW)) u_sum (
    .base_val(base_val), .base_en(base_en), .idx_val(idx_val), .idx_en(idx_en),
    .scale_sel(scale_sel), .disp_ext(disp_ext), .seg_base(seg_base),
    .wide_mode(wide_mode), .offset(offset_c), .linear(linear_c)
  );

  always_comb pay_in = {wide_mode, linear_c, offset_c};

  eagu_out_stage #(.PW(PW)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(pay_in), .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  always_comb begin
    held_wide  = pay_out[PW-1];
    out_linear = pay_out[2*AW-1:AW];
    out_offset = pay_out[AW-1:0];
  end

  // R8: narrow results never carry upper bits
  p_narrow_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !held_wide |-> (out_offset[AW-1:NW] == '0) && (out_linear[AW-1:NW] == '0));
endmodule

// File: tb/sim_eff_addr_gen.sv
module sim_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [63:0] base_val = '0, idx_val = '0, seg_base = '0;
  logic        base_en = 1'b0, idx_en = 1'b0, wide_mode = 1'b0;
  logic [1:0]  scale_sel = '0, disp_sz = '0;
  logic [31:0] disp_raw = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [63:0] out_offset, out_linear;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  eff_addr_gen u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] b, input logic be, input logic [63:0] ix,
                       input logic ie, input logic [1:0] sc, input logic [31:0] d,
                       input logic [1:0] dz, input logic w, input logic [63:0] sg);
    base_val = b; base_en = be; idx_val = ix; idx_en = ie; scale_sel = sc;
    disp_raw = d; disp_sz = dz; wide_mode = w; seg_base = sg;
  endtask

  // one request, consumer ready, result checked one cycle after acceptance
  task automatic xact(input string tag, input logic [63:0] eo, input logic [63:0] el);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R10 valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " offset"}, out_offset, eo);
    chk({tag, " linear"}, out_linear, el);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R12 in_ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_basic;  // R1 R2: 0x1000 + 3*4 - 4
    drive(64'h1000, 1, 64'd3, 1, 2'd2, 32'h0000_00FC, 2'b01, 0, 64'd0);
    xact("R1 R2 basic", 64'h1008, 64'h1008);
  endtask

  task automatic t_wide_neg;  // R3: disp32 0x80000000 -> -2^31 in 64-bit mode
    drive(64'h1_0000_0000, 1, 64'hFF, 0, 2'd0, 32'h8000_0000, 2'b10, 1, 64'd0);
    xact("R3 wide disp32", 64'h8000_0000, 64'h8000_0000);
  endtask

  task automatic t_no_base;  // R5 R7: disp32 as absolute base, segment added
    drive(64'hDEAD, 0, 64'd5, 1, 2'd3, 32'h0804_97E8, 2'b10, 0, 64'h100);
    xact("R5 R7 no base", 64'h0804_9810, 64'h0804_9910);
  endtask

  task automatic t_no_index;  // R6
    drive(64'h2000, 1, 64'hFF, 0, 2'd3, 32'h0, 2'b00, 1, 64'd0);
    xact("R6 no index", 64'h2000, 64'h2000);
  endtask

  task automatic t_rsvd;  // R4 reserved code 11
    drive(64'h3000, 1, 64'd0, 0, 2'd0, 32'h1234_5678, 2'b11, 1, 64'd0);
    xact("R4 reserved disp", 64'h3000, 64'h3000);
  endtask

  task automatic t_narrow_wrap;  // R8
    drive(64'hABCD_0000_FFFF_FFF0, 1, 64'd0, 0, 2'd0, 32'h20, 2'b01, 0,
          64'h1111_1111_FFFF_FFF8);
    xact("R8 narrow wrap", 64'h10, 64'h8);
  endtask

  task automatic t_wide_wrap;  // R9
    drive(64'hFFFF_FFFF_FFFF_FFF0, 1, 64'h10, 1, 2'd0, 32'h5, 2'b01, 1, 64'h10);
    xact("R9 wide wrap", 64'h5, 64'h15);
  endtask

  task automatic t_short_upper;  // R2: upper disp bits ignored, +127
    drive(64'h100, 1, 64'd0, 0, 2'd0, 32'hFFFF_FF7F, 2'b01, 0, 64'd0);
    xact("R2 short upper", 64'h17F, 64'h17F);
  endtask

  task automatic t_index_only;  // R5: no base, no disp, index*2
    drive(64'h5555, 0, 64'd7, 1, 2'd1, 32'hFFFF_FFFF, 2'b00, 0, 64'd0);
    xact("R5 index only", 64'hE, 64'hE);
  endtask

  task automatic t_backpressure;  // R11
    drive(64'h40, 1, 64'd0, 0, 2'd0, 32'h0, 2'b00, 1, 64'd0);
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    drive(64'h80, 1, 64'd0, 0, 2'd0, 32'h0, 2'b00, 1, 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 held valid", {63'd0, out_valid}, 64'd1);
      chk("R11 held offset", out_offset, 64'h40);
      chk("R11 in_ready low", {63'd0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next result", out_offset, 64'h80);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wide_neg();
    t_no_base();
    t_no_index();
    t_rsvd();
    t_narrow_wrap();
    t_wide_wrap();
    t_short_upper();
    t_index_only();
    t_backpressure();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule